// File: doc/BRIEF.md
# Packet Transmit Sequencer

This block turns bytes that a host has queued while the radio sits in standby into one serial packet frame. Once the mode input selects transmit and a warm-up delay has elapsed, it starts on its own, provided the queue holds at least one byte. It then shifts out, most significant bit first, a run of alternating preamble bytes, a 1- to 4-byte sync word, an optional length byte and the payload, followed by an optional 16-bit checksum. Each line chip is marked by a one-cycle bit-clock enable pulse.

The payload and checksum can be scrambled with a 9-bit pseudo-random sequence. Every bit of the frame can be split into two complementary chips. One bit period after the final chip, a transmit-done flag rises, and any bytes still left in the queue are discarded. The flag stays high until the mode leaves transmit.

The controller has these states: `ST_IDLE`, `ST_WARMUP`, `ST_PREAMBLE`, `ST_SYNC`, `ST_LENGTH`, `ST_PAYLOAD`, `ST_CRC`, `ST_TAIL` and `ST_DONE`. Its transitions are as follows.
- IDLE→WARMUP when the mode becomes transmit.
- WARMUP→PREAMBLE, or →SYNC when the preamble count is zero, once warm-up is over and the queue is non-empty.
- PREAMBLE→SYNC.
- SYNC→LENGTH in variable format. Otherwise SYNC→PAYLOAD, or →CRC or →TAIL when the length is zero.
- LENGTH→PAYLOAD, →CRC or →TAIL, by the same rule.
- PAYLOAD→CRC, or →TAIL when the checksum is off.
- CRC→TAIL.
- TAIL→DONE after one bit period.
- Any state→IDLE when the mode leaves transmit.

Top module: `pkt_tx_seq`

## Requirements
- R1: The mode input encodes sleep as 2'b00, standby as 2'b01 and transmit as 2'b10. A queue write (`wr_en_i` high) is stored only in standby and is ignored in every other mode. `fifo_nempty_o` is high when the queue holds a byte.
- R2: In transmit mode, the frame starts only after `WARMUP_CYCLES` cycles and only when the queue is non-empty. With an empty queue, no chip is emitted.
- R3: The frame begins with `pre_len_i` bytes of 8'hAA, followed by `sync_len_i`+1 sync bytes taken from `sync_word_i[31:24]` downward. Every byte is sent MSB first.
- R4: When `var_len_i` is 1, the first queued byte is sent unscrambled after the sync word and gives the payload byte count. When `var_len_i` is 0, the count is `fixed_len_i`.
- R5: When `crc_en_i` is 1, a CRC-16 is appended MSB first. It uses polynomial 0x1021 and seed 0xFFFF and is computed over the unscrambled length byte and payload bits. When `crc_en_i` is 0, no checksum is sent.
- R6: When `white_en_i` is 1, each payload and checksum bit is XORed with bit 0 of a 9-bit register. The register is set to 9'h1FF at frame start and, after each such bit, is replaced by {r[0]^r[5], r[8:1]}.
- R7: When `manch_en_i` is 1, every frame bit b, preamble and sync included, is sent as two chips: b, then ~b.
- R8: Each chip is presented on `ser_data_o` during a one-cycle `ser_bit_en_o` pulse. Within a frame, pulses are exactly `CLKS_PER_BIT` cycles apart.
- R9: `tx_done_o` rises `CLKS_PER_BIT` cycles after the last chip's pulse (twice that with split chips). It stays high while the mode remains transmit and drops when the mode leaves transmit.
- R10: When the frame completes, the queue is cleared, so bytes loaded beyond the packet length are discarded.
- R11: If the queue runs dry while payload bytes are still owed, each missing byte is sent as 8'h00.
- R12: Leaving transmit mode in the middle of a frame stops chip emission at once, and `tx_done_o` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode (sleep, standby, transmit) |
| wr_en_i | input | 1 | Queue write strobe |
| wr_data_i | input | 8 | Queue write byte |
| pre_len_i | input | PRE_W | Preamble length in bytes |
| sync_len_i | input | 2 | Sync word length minus one, in bytes |
| sync_word_i | input | 32 | Sync word, first byte in bits 31:24 |
| var_len_i | input | 1 | 1 = variable format with length byte |
| fixed_len_i | input | 8 | Payload length in fixed format |
| crc_en_i | input | 1 | Append checksum |
| white_en_i | input | 1 | Scramble payload and checksum |
| manch_en_i | input | 1 | Split each bit into two complementary chips |
| ser_data_o | output | 1 | Serial chip output |
| ser_bit_en_o | output | 1 | Chip strobe |
| tx_done_o | output | 1 | Frame complete flag |
| fifo_nempty_o | output | 1 | Queue holds at least one byte |

## Verification
The assertions take for granted that the configuration inputs stay steady while the mode is transmit. They also assume `CLKS_PER_BIT` is at least 2, so that chip pulses can never touch. The stimulus sets every configuration field in standby, before the mode changes. It loads at most the queue depth, never changes settings during a frame, and returns to sleep after each completion flag. The sweep covers every combination of format, checksum, scrambling and chip splitting, at several payload lengths, with varied preamble and sync sizes.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WARMUP,
        ST_PREAMBLE,
        ST_SYNC,
        ST_LENGTH,
        ST_PAYLOAD,
        ST_CRC,
        ST_TAIL,
        ST_DONE
    } tx_state_e;

    localparam logic [1:0] MODE_SLEEP = 2'b00;
    localparam logic [1:0] MODE_STBY  = 2'b01;
    localparam logic [1:0] MODE_TX    = 2'b10;

    localparam logic [7:0] PREAMBLE_BYTE = 8'hAA;

endpackage

// File: rtl/pkt_tx_fifo.sv
module pkt_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             empty_o
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [AW:0]      cnt_q;
    logic             full, wr_ok, rd_ok;

    assign empty_o = (cnt_q == '0);
    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign wr_ok   = wr_i && !full;
    assign rd_ok   = rd_i && !empty_o;
    assign rdata_o = mem_q[rd_ptr_q];

    always_ff @(posedge clk_i) begin
        if (wr_ok && !clr_i) begin
            mem_q[wr_ptr_q] <= wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (clr_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (wr_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
            if (rd_ok) rd_ptr_q <= rd_ptr_q + AW'(1);
            if (wr_ok && !rd_ok)      cnt_q <= cnt_q + (AW+1)'(1);
            else if (rd_ok && !wr_ok) cnt_q <= cnt_q - (AW+1)'(1);
        end
    end
endmodule

// File: rtl/pkt_tx_bitclk.sv
module pkt_tx_bitclk #(
    parameter int CLKS_PER_BIT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int            CW   = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CW'(1);
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pkt_tx_pn9.sv
module pkt_tx_pn9 (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic seed_i,
    input  logic step_i,
    output logic bit_o
);
    logic [8:0] lfsr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     lfsr_q <= 9'h1FF;
        else if (seed_i) lfsr_q <= 9'h1FF;
        else if (step_i) lfsr_q <= {lfsr_q[0] ^ lfsr_q[5], lfsr_q[8:1]};
    end

    assign bit_o = lfsr_q[0];
endmodule

// File: rtl/pkt_tx_crc16.sv
module pkt_tx_crc16 #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] SEED = 16'hFFFF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic init_i,
    input  logic feed_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic msb_o
);
    logic [15:0] crc_q;
    logic        fb;

    assign fb    = crc_q[15] ^ bit_i;
    assign msb_o = crc_q[15];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      crc_q <= SEED;
        else if (init_i)  crc_q <= SEED;
        else if (feed_i)  crc_q <= {crc_q[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
        else if (shift_i) crc_q <= {crc_q[14:0], 1'b0};
    end
endmodule

// File: rtl/pkt_tx_seq.sv
module pkt_tx_seq
    import pkt_tx_pkg::*;
#(
    parameter int FIFO_DEPTH    = 16,
    parameter int CLKS_PER_BIT  = 4,
    parameter int WARMUP_CYCLES = 16,
    parameter int PRE_W         = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       mode_i,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    input  logic [PRE_W-1:0] pre_len_i,
    input  logic [1:0]       sync_len_i,
    input  logic [31:0]      sync_word_i,
    input  logic             var_len_i,
    input  logic [7:0]       fixed_len_i,
    input  logic             crc_en_i,
    input  logic             white_en_i,
    input  logic             manch_en_i,
    output logic             ser_data_o,
    output logic             ser_bit_en_o,
    output logic             tx_done_o,
    output logic             fifo_nempty_o
);
    localparam int WCW = $clog2(WARMUP_CYCLES + 1);

    tx_state_e state_q, state_d;

    logic           tick, fifo_empty, pn_bit, crc_msb;
    logic [7:0]     fifo_head, head_or_zero, load_val;
    logic [7:0]     shreg_q, byte_cnt_q, pay_len_q;
    logic [2:0]     bit_idx_q;
    logic [WCW-1:0] warm_cnt_q;
    logic           manch_ph_q, tail_cnt_q;
    logic           in_tx, emitting, warm_done, tail_last;
    logic           raw_bit, white_act, coded_bit, chip;
    logic           chip_slot, bit_done, byte_done, sec_last, sec_end;
    logic           start, sec_change, load_new, fifo_pop, fifo_clr;
    logic [1:0]     sync_idx;
    tx_state_e      pay_next;

    function automatic logic [7:0] sync_byte(input logic [31:0] w, input logic [1:0] i);
        return w[8*(3-int'(i)) +: 8];
    endfunction

    // ---------------- sub-blocks ----------------
    pkt_tx_bitclk #(.CLKS_PER_BIT(CLKS_PER_BIT)) bitclk_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    pkt_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) fifo_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (fifo_clr),
        .wr_i    (wr_en_i && (mode_i == MODE_STBY)),
        .wdata_i (wr_data_i),
        .rd_i    (fifo_pop),
        .rdata_o (fifo_head),
        .empty_o (fifo_empty)
    );

    pkt_tx_pn9 pn9_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .seed_i (start),
        .step_i (bit_done && white_act),
        .bit_o  (pn_bit)
    );

    pkt_tx_crc16 crc_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .init_i  (start),
        .feed_i  (bit_done && crc_en_i && (state_q inside {ST_LENGTH, ST_PAYLOAD})),
        .shift_i (bit_done && (state_q == ST_CRC)),
        .bit_i   (raw_bit),
        .msb_o   (crc_msb)
    );

    // ---------------- chip datapath ----------------
    assign in_tx     = (mode_i == MODE_TX);
    assign emitting  = state_q inside {ST_PREAMBLE, ST_SYNC, ST_LENGTH, ST_PAYLOAD, ST_CRC};
    assign raw_bit   = (state_q == ST_CRC) ? crc_msb : shreg_q[7];
    assign white_act = white_en_i && (state_q inside {ST_PAYLOAD, ST_CRC});
    assign coded_bit = raw_bit ^ (white_act & pn_bit);
    assign chip      = (manch_en_i && manch_ph_q) ? ~coded_bit : coded_bit;
    assign chip_slot = tick && emitting && in_tx;
    assign bit_done  = chip_slot && (!manch_en_i || manch_ph_q);
    assign byte_done = bit_done && (bit_idx_q == 3'd7);

    always_comb begin
        unique case (state_q)
            ST_PREAMBLE: sec_last = (byte_cnt_q == 8'(pre_len_i) - 8'd1);
            ST_SYNC:     sec_last = (byte_cnt_q == 8'(sync_len_i));
            ST_LENGTH:   sec_last = 1'b1;
            ST_PAYLOAD:  sec_last = (byte_cnt_q == pay_len_q - 8'd1);
            ST_CRC:      sec_last = (byte_cnt_q == 8'd1);
            default:     sec_last = 1'b0;
        endcase
    end

    assign sec_end   = byte_done && sec_last;
    assign warm_done = (warm_cnt_q == WCW'(WARMUP_CYCLES));
    assign tail_last = manch_en_i ? tail_cnt_q : 1'b1;
    assign pay_next  = (pay_len_q != 8'd0) ? ST_PAYLOAD : (crc_en_i ? ST_CRC : ST_TAIL);

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (in_tx) state_d = ST_WARMUP;
            ST_WARMUP:   if (warm_done && !fifo_empty)
                             state_d = (pre_len_i != '0) ? ST_PREAMBLE : ST_SYNC;
            ST_PREAMBLE: if (sec_end) state_d = ST_SYNC;
            ST_SYNC:     if (sec_end) state_d = var_len_i ? ST_LENGTH : pay_next;
            ST_LENGTH:   if (sec_end) state_d = pay_next;
            ST_PAYLOAD:  if (sec_end) state_d = crc_en_i ? ST_CRC : ST_TAIL;
            ST_CRC:      if (sec_end) state_d = ST_TAIL;
            ST_TAIL:     if (tick && tail_last) state_d = ST_DONE;
            ST_DONE:     state_d = ST_DONE;
            default:     state_d = ST_IDLE;
        endcase
        if (!in_tx) state_d = ST_IDLE;
    end

    // ---------------- load / pop control ----------------
    assign start        = (state_q == ST_WARMUP) && (state_d inside {ST_PREAMBLE, ST_SYNC});
    assign sec_change   = (state_d != state_q);
    assign load_new     = (start || byte_done) &&
                          (state_d inside {ST_PREAMBLE, ST_SYNC, ST_LENGTH, ST_PAYLOAD});
    assign head_or_zero = fifo_empty ? 8'h00 : fifo_head;
    assign sync_idx     = (state_q != ST_SYNC) ? 2'd0 : 2'(byte_cnt_q + 8'd1);
    assign fifo_pop     = load_new && (state_d inside {ST_LENGTH, ST_PAYLOAD}) && !fifo_empty;
    assign fifo_clr     = (state_q == ST_TAIL) && (state_d == ST_DONE);

    always_comb begin
        unique case (state_d)
            ST_PREAMBLE: load_val = PREAMBLE_BYTE;
            ST_SYNC:     load_val = sync_byte(sync_word_i, sync_idx);
            default:     load_val = head_or_zero;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // ---------------- counters and shifter ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            warm_cnt_q <= '0;
            shreg_q    <= '0;
            bit_idx_q  <= '0;
            manch_ph_q <= 1'b0;
            byte_cnt_q <= '0;
            pay_len_q  <= '0;
            tail_cnt_q <= 1'b0;
        end else begin
            if (state_q == ST_WARMUP) begin
                if (!warm_done) warm_cnt_q <= warm_cnt_q + WCW'(1);
            end else begin
                warm_cnt_q <= '0;
            end

            if (load_new)      shreg_q <= load_val;
            else if (bit_done) shreg_q <= {shreg_q[6:0], 1'b0};

            if (start)         bit_idx_q <= '0;
            else if (bit_done) bit_idx_q <= bit_idx_q + 3'd1;

            if (start)                        manch_ph_q <= 1'b0;
            else if (chip_slot && manch_en_i) manch_ph_q <= ~manch_ph_q;

            if (sec_change)     byte_cnt_q <= '0;
            else if (byte_done) byte_cnt_q <= byte_cnt_q + 8'd1;

            if (start)                                  pay_len_q <= fixed_len_i;
            else if (load_new && state_d == ST_LENGTH)  pay_len_q <= head_or_zero;

            if (sec_change)                       tail_cnt_q <= 1'b0;
            else if (tick && state_q == ST_TAIL)  tail_cnt_q <= ~tail_cnt_q;
        end
    end

    // ---------------- outputs ----------------
    logic ser_data_q, ser_en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ser_data_q <= 1'b0;
            ser_en_q   <= 1'b0;
        end else begin
            ser_en_q   <= chip_slot;
            ser_data_q <= chip_slot ? chip : 1'b0;
        end
    end

    assign ser_data_o    = ser_data_q;
    assign ser_bit_en_o  = ser_en_q;
    assign tx_done_o     = (state_q == ST_DONE);
    assign fifo_nempty_o = !fifo_empty;

endmodule

// File: rtl/pkt_tx_seq_chk.sv
module pkt_tx_seq_chk
    import pkt_tx_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] mode_i,
    input logic       ser_bit_en_o,
    input logic       tx_done_o,
    input logic       fifo_nempty_o
);
    // R1: an empty queue stays empty outside standby
    p_wr_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i != MODE_STBY && !fifo_nempty_o) |=> !fifo_nempty_o);

    // R12: chips only follow a cycle in transmit mode
    p_emit_in_tx_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ser_bit_en_o |-> ($past(mode_i) == MODE_TX));

    // R8: chip strobes never touch
    p_chip_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ser_bit_en_o |=> !ser_bit_en_o);

    // R9: done holds while mode stays transmit
    p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_done_o && mode_i == MODE_TX) |=> tx_done_o);

    // R9: no chip while done
    p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_done_o |-> !ser_bit_en_o);

    // R10: queue is empty when done rises
    p_done_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tx_done_o) |-> !fifo_nempty_o);
endmodule

bind pkt_tx_seq pkt_tx_seq_chk chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_i),
    .ser_bit_en_o  (ser_bit_en_o),
    .tx_done_o     (tx_done_o),
    .fifo_nempty_o (fifo_nempty_o)
);

// File: tb/pkt_tx_seq_tb_top.sv
module pkt_tx_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 4;
    localparam int WARM       = 16;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_data_i = 8'h00;
    logic [3:0]  pre_len_i = '0;
    logic [1:0]  sync_len_i = '0;
    logic [31:0] sync_word_i = 32'hC3A5_1E97;
    logic        var_len_i = 1'b0;
    logic [7:0]  fixed_len_i = '0;
    logic        crc_en_i = 1'b0, white_en_i = 1'b0, manch_en_i = 1'b0;
    logic        ser_data_o, ser_bit_en_o, tx_done_o, fifo_nempty_o;

    pkt_tx_seq #(.FIFO_DEPTH(16), .CLKS_PER_BIT(CPB), .WARMUP_CYCLES(WARM), .PRE_W(4)) dut_i (
        .clk_i, .rst_ni, .mode_i, .wr_en_i, .wr_data_i, .pre_len_i, .sync_len_i,
        .sync_word_i, .var_len_i, .fixed_len_i, .crc_en_i, .white_en_i, .manch_en_i,
        .ser_data_o, .ser_bit_en_o, .tx_done_o, .fifo_nempty_o
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    always @(posedge clk_i) cyc <= cyc + 1;

    // collector
    logic got_bits [1024];
    int   got_n = 0, last_en_cyc = 0, irq_cyc = -1, bad_space = 0;
    logic done_prev = 1'b0;
    always @(negedge clk_i) begin
        if (rst_ni) begin
            if (ser_bit_en_o) begin
                if (got_n > 0 && (cyc - last_en_cyc) != CPB) bad_space = bad_space + 1;
                if (got_n < 1024) got_bits[got_n] = ser_data_o;
                got_n = got_n + 1;
                last_en_cyc = cyc;
            end
            if (tx_done_o && !done_prev) irq_cyc = cyc;
        end
        done_prev = tx_done_o;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected model
    logic       exp_bits [1024];
    int         exp_n;
    logic [15:0] crc_m;
    logic [8:0]  pn_m;
    logic        man_m;
    logic [7:0]  fifo_img [16];

    task automatic emit_bit(input logic b);
        exp_bits[exp_n] = b; exp_n++;
        if (man_m) begin exp_bits[exp_n] = ~b; exp_n++; end
    endtask

    task automatic model_byte(input logic [7:0] v, input logic feed, input logic wh);
        for (int k = 7; k >= 0; k--) begin
            logic r, c, fb;
            r = v[k];
            if (feed) begin
                fb = crc_m[15] ^ r;
                crc_m = {crc_m[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
            c = r;
            if (wh) begin
                c = r ^ pn_m[0];
                pn_m = {pn_m[0] ^ pn_m[5], pn_m[8:1]};
            end
            emit_bit(c);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_i); rst_ni = 1'b0; mode_i = 2'b00; wr_en_i = 1'b0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = b;
        @(negedge clk_i); wr_en_i = 1'b0;
    endtask

    task automatic run_frame(input int pre, input int syn, input logic vl, input int flen,
                             input logic ce, input logic we, input logic me, input int nload,
                             input string tag);
        int plen, base, mism, waited;
        logic [15:0] c;
        exp_n = 0; man_m = me; crc_m = 16'hFFFF; pn_m = 9'h1FF;
        for (int p = 0; p < pre; p++) model_byte(8'hAA, 1'b0, 1'b0);
        for (int s = 0; s <= syn; s++) model_byte(8'(sync_word_i >> (8*(3-s))), 1'b0, 1'b0);
        plen = vl ? int'(fifo_img[0]) : flen;
        base = vl ? 1 : 0;
        if (vl) model_byte(fifo_img[0], ce, 1'b0);
        for (int i = 0; i < plen; i++)
            model_byte((base + i < nload) ? fifo_img[base+i] : 8'h00, ce, we);
        if (ce) begin
            c = crc_m;
            model_byte(c[15:8], 1'b0, we);
            model_byte(c[7:0], 1'b0, we);
        end

        @(negedge clk_i);
        mode_i = 2'b01;
        pre_len_i = 4'(pre); sync_len_i = 2'(syn); var_len_i = vl; fixed_len_i = 8'(flen);
        crc_en_i = ce; white_en_i = we; manch_en_i = me;
        for (int i = 0; i < nload; i++) wr_byte(fifo_img[i]);
        @(negedge clk_i);
        got_n = 0; bad_space = 0; irq_cyc = -1;
        mode_i = 2'b10;
        waited = 0;
        while (!tx_done_o && waited < 20000) begin @(negedge clk_i); waited++; end
        @(negedge clk_i);

        mism = (got_n != exp_n) ? 1 : 0;
        for (int i = 0; i < exp_n && i < 1024; i++)
            if (got_bits[i] !== exp_bits[i]) mism++;
        check(mism == 0 && got_n == exp_n, {tag, " R3 R4 R5 R6 R7 frame chips"}, got_n, exp_n);
        check(bad_space == 0, {tag, " R8 chip spacing"}, bad_space, 0);
        check(irq_cyc - last_en_cyc == CPB * (me ? 2 : 1), {tag, " R9 done delay"},
              irq_cyc - last_en_cyc, CPB * (me ? 2 : 1));
        check(fifo_nempty_o == 1'b0, {tag, " R10 queue flushed"}, int'(fifo_nempty_o), 0);
        check(tx_done_o == 1'b1, {tag, " R9 done held"}, int'(tx_done_o), 1);
        mode_i = 2'b00;
        repeat (2) @(negedge clk_i);
        check(tx_done_o == 1'b0, {tag, " R9 done dropped"}, int'(tx_done_o), 0);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int idx, n0, waited;
        do_reset();
        check(ser_bit_en_o == 1'b0, "R8 reset strobe", int'(ser_bit_en_o), 0);
        check(tx_done_o == 1'b0, "R9 reset done", int'(tx_done_o), 0);
        check(fifo_nempty_o == 1'b0, "R1 reset queue", int'(fifo_nempty_o), 0);

        // R1: writes in sleep ignored
        mode_i = 2'b00;
        for (int i = 0; i < 3; i++) wr_byte(8'h55);
        @(negedge clk_i);
        check(fifo_nempty_o == 1'b0, "R1 sleep write ignored", int'(fifo_nempty_o), 0);

        // R2: transmit with empty queue, writes in transmit ignored
        got_n = 0;
        mode_i = 2'b10;
        for (int i = 0; i < 3; i++) wr_byte(8'h3C);
        repeat (300) @(negedge clk_i);
        check(got_n == 0, "R2 no chips with empty queue", got_n, 0);
        check(fifo_nempty_o == 1'b0, "R1 transmit write ignored", int'(fifo_nempty_o), 0);
        check(tx_done_o == 1'b0, "R2 no done with empty queue", int'(tx_done_o), 0);
        mode_i = 2'b00;
        @(negedge clk_i);

        // R1: standby write accepted
        mode_i = 2'b01;
        wr_byte(8'h00);
        @(negedge clk_i);
        check(fifo_nempty_o == 1'b1, "R1 standby write stored", int'(fifo_nempty_o), 1);
        do_reset();

        // sweep
        idx = 0;
        for (int m = 0; m < 2; m++)
            for (int w = 0; w < 2; w++)
                for (int c = 0; c < 2; c++)
                    for (int v = 0; v < 2; v++)
                        for (int li = 0; li < 3; li++) begin
                            int len, nl;
                            len = (li == 0) ? 0 : ((li == 1) ? 2 : 5);
                            if (v != 0) begin
                                fifo_img[0] = 8'(len);
                                for (int i = 0; i < len; i++) fifo_img[i+1] = 8'(idx*37 + i*11 + 5);
                                nl = len + 1;
                            end else begin
                                for (int i = 0; i < 6; i++) fifo_img[i] = 8'(idx*37 + i*11 + 5);
                                nl = (len == 0) ? 1 : len;
                            end
                            run_frame(idx % 3, idx % 4, v[0], len, c[0], w[0], m[0], nl, "sweep");
                            idx++;
                        end

        // R10: extra bytes discarded
        for (int i = 0; i < 5; i++) fifo_img[i] = 8'(8'hE1 + i*3);
        run_frame(1, 1, 1'b0, 2, 1'b1, 1'b0, 1'b0, 5, "R10 extra bytes");

        // R11: queue runs dry
        fifo_img[0] = 8'd3; fifo_img[1] = 8'h9B;
        run_frame(2, 0, 1'b1, 0, 1'b1, 1'b1, 1'b0, 2, "R11 shortfall");

        // R12: abort mid-frame
        @(negedge clk_i);
        mode_i = 2'b01; var_len_i = 1'b1; pre_len_i = 4'd2; sync_len_i = 2'd3;
        crc_en_i = 1'b1; white_en_i = 1'b0; manch_en_i = 1'b0;
        wr_byte(8'd8);
        for (int i = 0; i < 8; i++) wr_byte(8'(i));
        @(negedge clk_i);
        got_n = 0;
        mode_i = 2'b10;
        waited = 0;
        while (got_n < 20 && waited < 5000) begin @(negedge clk_i); waited++; end
        mode_i = 2'b01;
        @(negedge clk_i);
        n0 = got_n;
        repeat (100) @(negedge clk_i);
        check(got_n == n0, "R12 emission stopped", got_n, n0);
        check(tx_done_o == 1'b0, "R12 no done after abort", int'(tx_done_o), 0);
        do_reset();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule